// File: doc/BRIEF.md
# Transfer-Request Packet DMA Sequencer

This block is a single-channel DMA engine that runs one packet at a time. A packet is a descriptor in memory holding a header and a list of transfer-request records. While `work_pending` is high and the engine is idle, it reads a descriptor pointer from the ring slot at `ring_addr` and pulses `ring_pop` once that pointer has been taken. It then reads the header and works through the records in index order. For each record it reads every source word into an internal buffer and then writes the words out to the destination. When the status of the final write comes back, it writes a response word into the response slot whose index matches that record's index.

All memory traffic uses one request port with a single outstanding access. A request holds `mem_req` and its fields steady until one `mem_rsp_valid` cycle returns read data, or acknowledges the write, or reports an error. When the header enables reload, the engine goes back to the reload index after the last record instead of finishing. It keeps looping until `stop_req` is high at a wrap point. At the end of a packet, `pkt_done` pulses for one cycle, and `pkt_err` qualifies the pulse.

Memory is word addressed. The header word is laid out as follows: kind in bits [31:29], which must be 3'b101 for a transfer-request packet; reload enable in bit 28; reload index in [23:16]; last index (record count minus one) in [15:8]; record stride in words in [7:0]. Record i starts at descriptor+1+i*stride and holds three words: source address, destination address, and word count (bits [15:0]). Response slot i is at descriptor+1+(last+1)*stride+i. A response word carries a status code in bits [7:0]: 0 means done, 1 means memory error, 2 means bad count.

Top module: `trpkt_seq`

## Requirements
- R1: After reset, `mem_req`, `ring_pop` and `pkt_done` are low, and no access starts while `work_pending` is low.
- R2: A packet first reads `ring_addr` and then reads the header at the address returned. `ring_pop` pulses exactly once per packet.
- R3: A header is rejected if its kind is not 3'b101, if its stride is below 3, if reload is disabled with a nonzero reload index, or if the reload index exceeds the last index. A rejected header ends the packet with `pkt_err` high and no memory write.
- R4: Records are fetched in index order from descriptor+1+i*stride, reading the source, destination and count words in that order.
- R5: For each record, all count source reads (source+j, j ascending) complete before the first destination write. Word j lands at destination+j.
- R6: The response for record i is written only after the status of that record's last data write has returned. It goes to descriptor+1+(last+1)*stride+i with code 0.
- R7: A memory error on a record or data access writes code 1 into that record's slot. The packet then ends with `pkt_err` high and no further records are processed.
- R8: A record whose count is 0 or exceeds MAXW moves no data, gets code 2 in its slot, and ends the packet with `pkt_err` high.
- R9: `pkt_done` is a one-cycle pulse that comes only after the final response write has been acknowledged. `pkt_err` is low for a packet that completes without error.
- R10: With reload enabled, the engine restarts at the reload index after the last record whenever `stop_req` is low at that point. If `stop_req` is high there, the packet completes.
- R11: While `mem_req` is high and no response has arrived, the request address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| work_pending | input | 1 | Ring holds at least one descriptor pointer |
| ring_addr | input | AW | Address of the ring slot to read |
| stop_req | input | 1 | Ends a reload loop at the next wrap point |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | One-cycle response to the outstanding access |
| mem_rsp_err | input | 1 | The response reports an error |
| mem_rsp_data | input | DW | Read data |
| ring_pop | output | 1 | Pulse: a ring entry has been consumed |
| pkt_done | output | 1 | Pulse: the packet has ended |
| pkt_err | output | 1 | Error status, valid with `pkt_done` |

## Verification
The hardest situation to reach is the reload wrap decision. `stop_req` only matters in the single cycle in which the last record's response acknowledgement arrives. At every other moment the input is ignored. The bench counts response-slot writes in its memory model and raises `stop_req` in the same cycle that the chosen slot write is acknowledged. This lets it end a loop after exactly one pass through the reloaded part of the list and then compare the full sequence of accesses. Errors are injected by marking a single address as faulty, so that an error can land on a chosen word in the middle of a record.

// File: rtl/trpkt_seq.sv
module trpkt_seq #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int MAXW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          work_pending,
  input  logic [AW-1:0] ring_addr,
  input  logic          stop_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_err,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          ring_pop,
  output logic          pkt_done,
  output logic          pkt_err
);
  localparam int CW = $clog2(MAXW + 1);
  localparam int KW = (MAXW > 1) ? $clog2(MAXW) : 1;
  localparam logic [2:0] KIND_TR = 3'b101;
  localparam logic [7:0] C_OK = 8'd0, C_MEM = 8'd1, C_CNT = 8'd2;

  typedef enum logic [2:0] {S_IDLE, S_RING, S_HDR, S_TREC, S_DRD, S_DWR, S_RSP, S_FIN} st_t;
  st_t st;

  logic [AW-1:0] desc, src, dst;
  logic          rl_en, err_f, pop_q;
  logic [7:0]    rl_idx, last_idx, stride, idx, code;
  logic [1:0]    sub;
  logic [CW-1:0] cnt, k;
  logic [DW-1:0] dbuf [MAXW];

  wire ok  = mem_rsp_valid && !mem_rsp_err;
  wire bad = mem_rsp_valid &&  mem_rsp_err;

  wire [2:0] h_kind   = mem_rsp_data[31:29];
  wire       h_rl     = mem_rsp_data[28];
  wire [7:0] h_rlidx  = mem_rsp_data[23:16];
  wire [7:0] h_last   = mem_rsp_data[15:8];
  wire [7:0] h_stride = mem_rsp_data[7:0];
  wire h_bad = (h_kind != KIND_TR) || (h_stride < 8'd3) ||
               (!h_rl && h_rlidx != 8'd0) || (h_rl && h_rlidx > h_last);

  wire [15:0] cnt_word = mem_rsp_data[15:0];
  wire        cnt_bad  = (cnt_word == 16'd0) || (cnt_word > 16'(MAXW));

  wire [15:0] rec_off  = 16'(idx) * 16'(stride);
  wire [15:0] rsp_off  = (16'(last_idx) + 16'd1) * 16'(stride);
  wire [AW-1:0] tr_a   = desc + AW'(1) + AW'(rec_off) + AW'(sub);
  wire [AW-1:0] rsp_a  = desc + AW'(1) + AW'(rsp_off) + AW'(idx);
  wire          k_last = (k == cnt - CW'(1));

  assign mem_req   = (st != S_IDLE) && (st != S_FIN);
  assign mem_we    = (st == S_DWR) || (st == S_RSP);
  assign mem_wdata = (st == S_RSP) ? DW'(code) : dbuf[k[KW-1:0]];
  assign ring_pop  = pop_q;
  assign pkt_done  = (st == S_FIN);
  assign pkt_err   = (st == S_FIN) && err_f;

  always_comb begin
    case (st)
      S_RING:  mem_addr = ring_addr;
      S_HDR:   mem_addr = desc;
      S_TREC:  mem_addr = tr_a;
      S_DRD:   mem_addr = src + AW'(k);
      S_DWR:   mem_addr = dst + AW'(k);
      S_RSP:   mem_addr = rsp_a;
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (st == S_DRD && ok) dbuf[k[KW-1:0]] <= mem_rsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; desc <= '0; src <= '0; dst <= '0;
      rl_en <= 1'b0; rl_idx <= '0; last_idx <= '0; stride <= '0;
      idx <= '0; sub <= '0; cnt <= '0; k <= '0; code <= '0;
      err_f <= 1'b0; pop_q <= 1'b0;
    end else begin
      pop_q <= 1'b0;
      case (st)
        S_IDLE: if (work_pending) begin
          st <= S_RING; err_f <= 1'b0;
        end
        S_RING: if (bad) begin
          err_f <= 1'b1; st <= S_FIN;
        end else if (ok) begin
          desc <= mem_rsp_data[AW-1:0]; pop_q <= 1'b1; st <= S_HDR;
        end
        S_HDR: if (bad || (ok && h_bad)) begin
          err_f <= 1'b1; st <= S_FIN;
        end else if (ok) begin
          rl_en <= h_rl; rl_idx <= h_rlidx; last_idx <= h_last; stride <= h_stride;
          idx <= '0; sub <= '0; st <= S_TREC;
        end
        S_TREC: if (bad) begin
          code <= C_MEM; st <= S_RSP;
        end else if (ok) begin
          sub <= sub + 2'd1;
          case (sub)
            2'd0:    src <= mem_rsp_data[AW-1:0];
            2'd1:    dst <= mem_rsp_data[AW-1:0];
            default: begin
              sub <= '0;
              if (cnt_bad) begin
                code <= C_CNT; st <= S_RSP;
              end else begin
                cnt <= CW'(cnt_word); k <= '0; st <= S_DRD;
              end
            end
          endcase
        end
        S_DRD: if (bad) begin
          code <= C_MEM; st <= S_RSP;
        end else if (ok) begin
          if (k_last) begin k <= '0; st <= S_DWR; end
          else k <= k + CW'(1);
        end
        S_DWR: if (bad) begin
          code <= C_MEM; st <= S_RSP;
        end else if (ok) begin
          if (k_last) begin code <= C_OK; st <= S_RSP; end
          else k <= k + CW'(1);
        end
        S_RSP: if (bad || (ok && code != C_OK)) begin
          err_f <= 1'b1; st <= S_FIN;
        end else if (ok) begin
          sub <= '0;
          if (idx != last_idx) begin
            idx <= idx + 8'd1; st <= S_TREC;
          end else if (rl_en && !stop_req) begin
            idx <= rl_idx; st <= S_TREC;
          end else begin
            st <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !mem_req);
  p_pop_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ring_pop |-> ($past(mem_rsp_valid) && !$past(mem_we)));
  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TREC) |-> (idx <= last_idx));
  p_rsp_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_RSP) |-> $past(mem_rsp_valid));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
  p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_done) |-> $past(mem_rsp_valid));
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/trpkt_seq_tb_top.sv
module trpkt_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic work_pending = 1'b0, stop_req = 1'b0;
  logic [15:0] ring_addr = 16'h0010;
  logic mem_req, mem_we, ring_pop, pkt_done, pkt_err;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic rsp_v = 1'b0, rsp_e = 1'b0;
  logic [31:0] rsp_d = '0;

  always #2 clk = ~clk;

  trpkt_seq dut_i (
    .clk(clk), .rst_n(rst_n), .work_pending(work_pending), .ring_addr(ring_addr),
    .stop_req(stop_req), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(rsp_v), .mem_rsp_err(rsp_e),
    .mem_rsp_data(rsp_d), .ring_pop(ring_pop), .pkt_done(pkt_done), .pkt_err(pkt_err));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [256];
  int lat = 1, err_a = -1, rbase = 0, rwr = 0;
  logic busy = 1'b0; int cd = 0; logic [15:0] pa; logic pw; logic [31:0] pd;
  bit lgw [512]; int lga [512]; int lgn = 0;
  bit exw [512]; int exa [512]; int exn = 0;
  int cnts [3];

  always @(posedge clk) begin
    rsp_v <= 1'b0; rsp_e <= 1'b0;
    if (mem_req && !rsp_v && !busy) begin
      busy <= 1'b1; cd <= lat; pa <= mem_addr; pw <= mem_we; pd <= mem_wdata;
      if (lgn < 512) begin lgw[lgn] <= mem_we; lga[lgn] <= int'(mem_addr); lgn <= lgn + 1; end
    end else if (busy) begin
      if (cd == 0) begin
        busy <= 1'b0; rsp_v <= 1'b1;
        if (int'(pa) == err_a) rsp_e <= 1'b1;
        else if (pw) begin
          mem[pa[7:0]] <= pd;
          if (int'(pa) >= rbase && int'(pa) < rbase + 3) rwr <= rwr + 1;
        end else rsp_d <= mem[pa[7:0]];
      end else cd <= cd - 1;
    end
  end

  task automatic chk(input bit c, input string req, input int act, input int exp);
    n_chk++;
    if (!c) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic ex(input bit w, input int a);
    exw[exn] = w; exa[exn] = a; exn++;
  endtask

  function automatic int rec_a(int i); return 'h41 + i * 4; endfunction
  function automatic int src_a(int i); return 'h80 + i * 8; endfunction
  function automatic int dst_a(int i); return 'hC0 + i * 8; endfunction

  task automatic ex_rec(input int i);
    for (int s = 0; s < 3; s++) ex(0, rec_a(i) + s);
    for (int j = 0; j < cnts[i]; j++) ex(0, src_a(i) + j);
    for (int j = 0; j < cnts[i]; j++) ex(1, dst_a(i) + j);
    ex(1, rbase + i);
  endtask

  task automatic setup(input int n, input bit rl, input int rli, input int kind, input int stride);
    for (int a = 0; a < 256; a++) mem[a] = '0;
    mem['h10] = 32'h40;
    mem['h40] = {kind[2:0], rl, 4'd0, rli[7:0], 8'(n - 1), stride[7:0]};
    for (int i = 0; i < n; i++) begin
      mem[rec_a(i)] = src_a(i); mem[rec_a(i) + 1] = dst_a(i); mem[rec_a(i) + 2] = cnts[i];
      for (int j = 0; j < 8; j++) mem[src_a(i) + j] = 32'hA500_0000 + src_a(i) + j;
    end
    rbase = 'h41 + n * 4; rwr = 0;
    lgn = 0; exn = 0; err_a = -1;
    ex(0, 'h10); ex(0, 'h40);
  endtask

  int pops, dones, last_err, wide;
  task automatic run(input int stop_at);
    int t; pops = 0; dones = 0; last_err = 0; wide = 0; t = 0;
    work_pending = 1'b1;
    while (dones == 0 && t < 20000) begin
      @(negedge clk); t++;
      if (ring_pop) begin pops++; work_pending = 1'b0; end
      if (stop_at > 0 && rwr == stop_at) stop_req = 1'b1;
      if (pkt_done) begin dones++; last_err = pkt_err; end
    end
    @(negedge clk); if (pkt_done) wide = 1;
    stop_req = 1'b0; work_pending = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_log(input string req);
    bit m = (lgn == exn); int at = -1;
    for (int i = 0; i < exn && i < lgn; i++)
      if (m && (lgw[i] != exw[i] || lga[i] != exa[i])) begin m = 0; at = i; end
    if (at < 0 && !m) at = (lgn < exn) ? lgn : exn;
    chk(m, req, (at >= 0 && at < lgn) ? lga[at] : lgn, (at >= 0 && at < exn) ? exa[at] : exn);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!mem_req, "R1 req after reset", mem_req, 0);
    chk(!pkt_done && !ring_pop, "R1 done/pop after reset", {pkt_done, ring_pop}, 0);
    repeat (5) @(negedge clk);
    chk(!mem_req && lgn == 0, "R1 idle without work", lgn, 0);
  endtask

  task automatic t_basic(input int l);
    lat = l; cnts[0] = 2; cnts[1] = 3;
    setup(2, 0, 0, 5, 4); ex_rec(0); ex_rec(1);
    run(0);
    cmp_log("R2 R4 R5 R6 access order");
    chk(pops == 1, "R2 one pop", pops, 1);
    chk(dones == 1 && wide == 0, "R9 single done pulse", dones + wide, 1);
    chk(last_err == 0, "R9 no error", last_err, 0);
    chk(mem[dst_a(1) + 2] == 32'hA500_0000 + src_a(1) + 2, "R5 data moved", mem[dst_a(1) + 2], src_a(1) + 2);
    chk(mem[rbase] == 0 && mem[rbase + 1] == 0, "R6 ok codes", mem[rbase + 1], 0);
  endtask

  task automatic t_memerr;
    lat = 1; cnts[0] = 2; cnts[1] = 3;
    setup(2, 0, 0, 5, 4); err_a = src_a(1) + 1;
    mem[rbase + 1] = 32'hFF;
    ex_rec(0);
    for (int s = 0; s < 3; s++) ex(0, rec_a(1) + s);
    ex(0, src_a(1)); ex(0, src_a(1) + 1); ex(1, rbase + 1);
    run(0);
    cmp_log("R7 stops after error");
    chk(mem[rbase + 1] == 1, "R7 code 1 in slot", mem[rbase + 1], 1);
    chk(last_err == 1, "R7 packet error", last_err, 1);
    chk(mem[dst_a(1)] == 0, "R7 no write of failed record", mem[dst_a(1)], 0);
  endtask

  task automatic t_badcnt;
    lat = 0; cnts[0] = 1; cnts[1] = 9;
    setup(2, 0, 0, 5, 4);
    ex_rec(0);
    for (int s = 0; s < 3; s++) ex(0, rec_a(1) + s);
    ex(1, rbase + 1);
    run(0);
    cmp_log("R8 no data for bad count");
    chk(mem[rbase + 1] == 2 && last_err == 1, "R8 code 2", mem[rbase + 1], 2);
    cnts[0] = 0;
    setup(1, 0, 0, 5, 4);
    for (int s = 0; s < 3; s++) ex(0, rec_a(0) + s);
    ex(1, rbase);
    run(0);
    cmp_log("R8 zero count");
  endtask

  task automatic t_badhdr(input int kind, input bit rl, input int rli, input int stride, input string tag);
    int w = 0;
    lat = 1; cnts[0] = 1; cnts[1] = 1;
    setup(2, rl, rli, kind, stride);
    run(0);
    for (int i = 0; i < lgn; i++) if (lgw[i]) w++;
    chk(last_err == 1 && dones == 1, tag, last_err, 1);
    cmp_log(tag);
    chk(w == 0, "R3 no writes", w, 0);
  endtask

  task automatic t_reload;
    lat = 1; cnts[0] = 1; cnts[1] = 2; cnts[2] = 1;
    setup(3, 1, 1, 5, 4);
    ex_rec(0); ex_rec(1); ex_rec(2); ex_rec(1); ex_rec(2);
    run(5);
    cmp_log("R10 loop then stop");
    chk(last_err == 0 && dones == 1, "R10 clean completion", last_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic(1);
    t_basic(0);
    t_basic(3);
    t_memerr();
    t_badcnt();
    t_badhdr(3, 0, 0, 4, "R3 wrong kind");
    t_badhdr(5, 0, 1, 4, "R3 reload index without enable");
    t_badhdr(5, 1, 2, 4, "R3 reload index past last");
    t_badhdr(5, 0, 0, 2, "R3 short stride");
    t_reload();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule